// File: doc/BRIEF.md
# PCI Host Bridge Control Register Block

This block is the processor-facing register front end of a conventional PCI host bridge. It sits on a 32-bit processor bus with a valid/ready handshake. It answers accesses in a small register window that holds four things: a local copy of the bridge's 256-byte configuration header, a configuration address pointer, a memory base register and an I/O base register. A data port in the same window turns each processor access into one indirect configuration read or write toward the PCI side. That request goes out on a simple single-pulse request and response interface, addressed by the pointer.

The block also decodes a 256 KiB I/O window in processor address space. The window base comes from the upper bits of the I/O base register, so software can move it at run time. Accesses that fall inside it are passed straight to an I/O port interface, carrying the offset into the window. Register-window accesses complete in the cycle they are presented. Data-port accesses stall the processor until the PCI side responds. Any other address completes at once, reads as zero and changes nothing.

Top module: `pcib_host_ctrl`

## Requirements
- R1: In the register window, only accesses with all four byte enables set (`cpu_be` = 4'hF) take effect. Any other byte-enable pattern reads zero, completes in the same cycle and changes no register.
- R2: Offsets 0x000 to 0x0FC read and write the 64-word configuration header copy, one little-endian 32-bit word per aligned offset. After reset, the word at offset 0x004 holds {STS_INIT, CMD_INIT} with status in bits 31:16. Every other header word is zero.
- R3: Offset 0x1C0 is the configuration address pointer. It stores all 32 written bits, reads them back unchanged and is zero after reset.
- R4: Offset 0x1C4 is the memory base register. It keeps bits 31:24 and bit 0 of a write, reads zero in bits 23:1 and is zero after reset.
- R5: Offset 0x1C8 is the I/O base register. It is 0xFE240000 after reset and keeps bits 31:18 and bit 0. A write updates it only when bits 31:18 of the written value differ from the stored bits 31:18. Otherwise the whole register, bit 0 included, is left unchanged.
- R6: A processor address outside the register window whose bits 31:18 equal the I/O base bits 31:18 raises `io_valid` in the same cycle. It forwards address bits 17:0 on `io_addr`, together with the write flag, write data and byte enables. `cpu_ready` and `cpu_rdata` follow `io_ready` and `io_rdata`. An address outside both windows leaves `io_valid` low.
- R7: A full-word write to offset 0x220 raises `cfg_req_valid` for exactly one cycle, in the cycle after the access is presented. It carries `cfg_req_write` = 1, `cfg_req_addr` equal to the pointer value and `cfg_req_wdata` equal to the written data. `cpu_ready` stays low until `cfg_rsp_valid` arrives in a later cycle, and the access completes in that cycle.
- R8: A full-word read of offset 0x220 issues the same one-cycle request with `cfg_req_write` = 0. It completes in the cycle of `cfg_rsp_valid`, returning `cfg_rsp_rdata` on `cpu_rdata`.
- R9: Offsets inside the 0x224-byte register window that map to no register, and addresses outside both windows, complete in the same cycle. They read zero, and writes to them change no register.
- R10: Header and control register accesses complete combinationally: `cpu_ready` is high and `cpu_rdata` is valid in the cycle the access is presented, and a write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor access present; held until `cpu_ready` |
| cpu_write | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cfg_req_valid | output | 1 | One-cycle configuration request pulse |
| cfg_req_write | output | 1 | Configuration request is a write |
| cfg_req_addr | output | 32 | Configuration address (pointer value) |
| cfg_req_wdata | output | 32 | Configuration write data |
| cfg_rsp_valid | input | 1 | Configuration response |
| cfg_rsp_rdata | input | 32 | Configuration read data |
| io_valid | output | 1 | I/O window access |
| io_write | output | 1 | I/O access is a write |
| io_addr | output | 18 | Offset into the I/O window |
| io_wdata | output | 32 | I/O write data |
| io_be | output | 4 | I/O byte enables |
| io_ready | input | 1 | I/O access completes |
| io_rdata | input | 32 | I/O read data |

## Verification
The bench builds the block with its default parameters:
- a register window at 0x1E200000;
- an 18-bit I/O window offset;
- a 64-word header;
- a command/status reset pair of 0x0080/0x0290.

The non-zero command and status words make the reset contents of the header visibly distinct from the zero-filled words around them. With the default I/O base of 0xFE240000, a hit and a miss can be placed one window apart. Moving the base both with and without a change in bits 31:18 exercises the conditional update. Data-port responses are returned with latencies of zero and several cycles, so the stall and the single request pulse are observed in both situations.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

    localparam int unsigned CPU_AW = 32;
    localparam int unsigned CPU_DW = 32;
    localparam int unsigned CPU_BW = CPU_DW / 8;
    localparam int unsigned OFF_W  = 10;

    localparam logic [OFF_W-1:0] OFF_PTR    = 10'h1C0;
    localparam logic [OFF_W-1:0] OFF_MBASE  = 10'h1C4;
    localparam logic [OFF_W-1:0] OFF_IOBASE = 10'h1C8;
    localparam logic [OFF_W-1:0] OFF_DPORT  = 10'h220;
    localparam logic [OFF_W-1:0] WIN_LEN    = 10'h224;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_HDR,
        RG_PTR,
        RG_MBASE,
        RG_IOBASE,
        RG_DPORT,
        RG_IOWIN
    } region_e;

    typedef enum logic [1:0] {
        DP_IDLE,
        DP_ISSUE,
        DP_WAIT
    } dp_state_e;

    typedef struct packed {
        logic              write;
        logic [CPU_DW-1:0] wdata;
        logic [CPU_AW-1:0] addr;
    } cfg_req_t;

    // Mask keeping the top n bits plus bit 0.
    function automatic logic [CPU_DW-1:0] keep_upper(input int unsigned n);
        logic [CPU_DW-1:0] m;
        m = '0;
        for (int i = 0; i < CPU_DW; i++) begin
            if (i >= CPU_DW - n) m[i] = 1'b1;
        end
        m[0] = 1'b1;
        return m;
    endfunction

    function automatic logic full_word(input logic [CPU_BW-1:0] be);
        return &be;
    endfunction

endpackage

// File: rtl/pcib_decode.sv
module pcib_decode
    import pcib_pkg::*;
#(
    parameter logic [31:0] REG_BASE    = 32'h1E20_0000,
    parameter int unsigned IO_WIN_BITS = 18,
    parameter int unsigned HDR_WORDS   = 64
) (
    input  logic [CPU_AW-1:0]           addr,
    input  logic [CPU_AW-1:IO_WIN_BITS] io_base_hi,
    output region_e                     region,
    output logic [OFF_W-1:0]            offset,
    output logic [IO_WIN_BITS-1:0]      io_off
);
    localparam int unsigned HDR_BYTES = HDR_WORDS * 4;

    logic in_reg_win;
    logic in_io_win;

    assign offset     = addr[OFF_W-1:0];
    assign io_off     = addr[IO_WIN_BITS-1:0];
    assign in_reg_win = (addr[CPU_AW-1:OFF_W] == REG_BASE[CPU_AW-1:OFF_W]) &&
                        (addr[OFF_W-1:0] < WIN_LEN);
    assign in_io_win  = (addr[CPU_AW-1:IO_WIN_BITS] == io_base_hi);

    always_comb begin
        region = RG_NONE;
        if (in_reg_win) begin
            if (32'(offset) < HDR_BYTES && offset[1:0] == 2'b00) region = RG_HDR;
            else if (offset == OFF_PTR)    region = RG_PTR;
            else if (offset == OFF_MBASE)  region = RG_MBASE;
            else if (offset == OFF_IOBASE) region = RG_IOBASE;
            else if (offset == OFF_DPORT)  region = RG_DPORT;
        end else if (in_io_win) begin
            region = RG_IOWIN;
        end
    end
endmodule

// File: rtl/pcib_cfg_hdr.sv
module pcib_cfg_hdr
    import pcib_pkg::*;
#(
    parameter int unsigned HDR_WORDS = 64,
    parameter logic [15:0] CMD_INIT  = 16'h0080,
    parameter logic [15:0] STS_INIT  = 16'h0290,
    localparam int unsigned IDX_W    = $clog2(HDR_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CPU_DW-1:0] wdata,
    output logic [CPU_DW-1:0] rdata
);
    localparam int unsigned CMDSTS_IDX = 1;

    logic [CPU_DW-1:0] words [HDR_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HDR_WORDS; i++) begin
                words[i] <= (i == CMDSTS_IDX) ? {STS_INIT, CMD_INIT} : '0;
            end
        end else if (we) begin
            words[idx] <= wdata;
        end
    end

    assign rdata = words[idx];
endmodule

// File: rtl/pcib_ctrl_regs.sv
module pcib_ctrl_regs
    import pcib_pkg::*;
#(
    parameter logic [31:0] IOBASE_RST      = 32'hFE24_0000,
    parameter int unsigned IO_WIN_BITS     = 18,
    parameter int unsigned MBASE_KEEP_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  region_e           region,
    input  logic [CPU_DW-1:0] wdata,
    output logic [CPU_DW-1:0] ptr,
    output logic [CPU_DW-1:0] mbase,
    output logic [CPU_DW-1:0] iobase
);
    localparam logic [CPU_DW-1:0] MB_KEEP = keep_upper(MBASE_KEEP_BITS);
    localparam logic [CPU_DW-1:0] IO_KEEP = keep_upper(CPU_DW - IO_WIN_BITS);

    logic io_hi_differs;
    assign io_hi_differs = wdata[CPU_DW-1:IO_WIN_BITS] != iobase[CPU_DW-1:IO_WIN_BITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            mbase  <= '0;
            iobase <= IOBASE_RST & IO_KEEP;
        end else if (we) begin
            case (region)
                RG_PTR:    ptr   <= wdata;
                RG_MBASE:  mbase <= wdata & MB_KEEP;
                RG_IOBASE: if (io_hi_differs) iobase <= wdata & IO_KEEP;
                default: ;
            endcase
        end
    end

    // R5
    iobase_same_hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (we && region == RG_IOBASE && !io_hi_differs) |=> $stable(iobase));

    // R5
    iobase_new_hi_take_chk: assert property (@(posedge clk) disable iff (rst)
        (we && region == RG_IOBASE && io_hi_differs) |=>
            (iobase[CPU_DW-1:IO_WIN_BITS] == $past(wdata[CPU_DW-1:IO_WIN_BITS])));
endmodule

// File: rtl/pcib_dport.sv
module pcib_dport
    import pcib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              write,
    input  logic [CPU_DW-1:0] wdata,
    input  logic [CPU_AW-1:0] ptr,
    input  logic              rsp_valid,
    output logic              req_valid,
    output cfg_req_t          req,
    output logic              done,
    output logic              busy
);
    dp_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DP_IDLE;
            req   <= '0;
        end else begin
            case (state)
                DP_IDLE: if (start) begin
                    state     <= DP_ISSUE;
                    req.write <= write;
                    req.wdata <= wdata;
                    req.addr  <= ptr;
                end
                DP_ISSUE: state <= DP_WAIT;
                DP_WAIT:  if (rsp_valid) state <= DP_IDLE;
                default:  state <= DP_IDLE;
            endcase
        end
    end

    assign req_valid = (state == DP_ISSUE);
    assign done      = (state == DP_WAIT) && rsp_valid;
    assign busy      = (state != DP_IDLE);

    // R7
    cfg_req_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R8
    cfg_req_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> req_valid);
endmodule

// File: rtl/pcib_host_ctrl.sv
module pcib_host_ctrl
    import pcib_pkg::*;
#(
    parameter logic [31:0] REG_BASE        = 32'h1E20_0000,
    parameter logic [31:0] IOBASE_RST      = 32'hFE24_0000,
    parameter int unsigned IO_WIN_BITS     = 18,
    parameter int unsigned MBASE_KEEP_BITS = 8,
    parameter int unsigned HDR_WORDS       = 64,
    parameter logic [15:0] CMD_INIT        = 16'h0080,
    parameter logic [15:0] STS_INIT        = 16'h0290
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cpu_valid,
    input  logic                   cpu_write,
    input  logic [31:0]            cpu_addr,
    input  logic [31:0]            cpu_wdata,
    input  logic [3:0]             cpu_be,
    output logic                   cpu_ready,
    output logic [31:0]            cpu_rdata,
    output logic                   cfg_req_valid,
    output logic                   cfg_req_write,
    output logic [31:0]            cfg_req_addr,
    output logic [31:0]            cfg_req_wdata,
    input  logic                   cfg_rsp_valid,
    input  logic [31:0]            cfg_rsp_rdata,
    output logic                   io_valid,
    output logic                   io_write,
    output logic [IO_WIN_BITS-1:0] io_addr,
    output logic [31:0]            io_wdata,
    output logic [3:0]             io_be,
    input  logic                   io_ready,
    input  logic [31:0]            io_rdata
);
    localparam int unsigned IDX_W = $clog2(HDR_WORDS);

    region_e           region;
    logic [OFF_W-1:0]  offset;
    logic              acc_ok;
    logic              hdr_we;
    logic              reg_we;
    logic [CPU_DW-1:0] hdr_rdata;
    logic [CPU_DW-1:0] ptr, mbase, iobase;
    logic              dp_start, dp_done, dp_busy;
    cfg_req_t          dp_req;

    pcib_decode #(
        .REG_BASE    (REG_BASE),
        .IO_WIN_BITS (IO_WIN_BITS),
        .HDR_WORDS   (HDR_WORDS)
    ) u_decode (
        .addr       (cpu_addr),
        .io_base_hi (iobase[CPU_AW-1:IO_WIN_BITS]),
        .region     (region),
        .offset     (offset),
        .io_off     (io_addr)
    );

    pcib_cfg_hdr #(
        .HDR_WORDS (HDR_WORDS),
        .CMD_INIT  (CMD_INIT),
        .STS_INIT  (STS_INIT)
    ) u_hdr (
        .clk   (clk),
        .rst   (rst),
        .we    (hdr_we),
        .idx   (offset[IDX_W+1:2]),
        .wdata (cpu_wdata),
        .rdata (hdr_rdata)
    );

    pcib_ctrl_regs #(
        .IOBASE_RST      (IOBASE_RST),
        .IO_WIN_BITS     (IO_WIN_BITS),
        .MBASE_KEEP_BITS (MBASE_KEEP_BITS)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .region (region),
        .wdata  (cpu_wdata),
        .ptr    (ptr),
        .mbase  (mbase),
        .iobase (iobase)
    );

    pcib_dport u_dport (
        .clk       (clk),
        .rst       (rst),
        .start     (dp_start),
        .write     (cpu_write),
        .wdata     (cpu_wdata),
        .ptr       (ptr),
        .rsp_valid (cfg_rsp_valid),
        .req_valid (cfg_req_valid),
        .req       (dp_req),
        .done      (dp_done),
        .busy      (dp_busy)
    );

    assign cfg_req_write = dp_req.write;
    assign cfg_req_addr  = dp_req.addr;
    assign cfg_req_wdata = dp_req.wdata;

    assign io_write = cpu_write;
    assign io_wdata = cpu_wdata;
    assign io_be    = cpu_be;

    assign acc_ok = cpu_valid && full_word(cpu_be);

    always_comb begin
        cpu_ready = 1'b1;
        cpu_rdata = '0;
        io_valid  = 1'b0;
        hdr_we    = 1'b0;
        reg_we    = 1'b0;
        dp_start  = 1'b0;
        case (region)
            RG_IOWIN: begin
                io_valid  = cpu_valid;
                cpu_ready = io_ready;
                cpu_rdata = io_rdata;
            end
            RG_HDR: if (acc_ok) begin
                cpu_rdata = hdr_rdata;
                hdr_we    = cpu_write;
            end
            RG_PTR: if (acc_ok) begin
                cpu_rdata = ptr;
                reg_we    = cpu_write;
            end
            RG_MBASE: if (acc_ok) begin
                cpu_rdata = mbase;
                reg_we    = cpu_write;
            end
            RG_IOBASE: if (acc_ok) begin
                cpu_rdata = iobase;
                reg_we    = cpu_write;
            end
            RG_DPORT: if (acc_ok) begin
                cpu_ready = dp_done;
                cpu_rdata = dp_done ? cfg_rsp_rdata : '0;
                dp_start  = !dp_busy;
            end
            default: ;
        endcase
    end

    // R7
    dport_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (dp_busy && !cfg_rsp_valid && cpu_valid) |-> !cpu_ready);

    // R7
    ptr_steady_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (dp_busy && cpu_valid) |=> $stable(ptr));

    // R1
    partial_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && !full_word(cpu_be) && region != RG_IOWIN) |=>
            ($stable(ptr) && $stable(mbase) && $stable(iobase)));

    // R6
    io_needs_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        io_valid |-> cpu_valid);
endmodule

// File: tb/tb_pcib_host_ctrl.sv
module tb_pcib_host_ctrl;
    localparam logic [31:0] RB   = 32'h1E20_0000;
    localparam logic [15:0] CMD  = 16'h0080;
    localparam logic [15:0] STS  = 16'h0290;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = 4'hF;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        cfg_req_valid, cfg_req_write;
    logic [31:0] cfg_req_addr, cfg_req_wdata;
    logic        cfg_rsp_valid = 1'b0;
    logic [31:0] cfg_rsp_rdata = '0;
    logic        io_valid, io_write;
    logic [17:0] io_addr;
    logic [31:0] io_wdata;
    logic [3:0]  io_be;
    logic        io_ready = 1'b1;
    logic [31:0] io_rdata = '0;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_hdr [64];
    logic [31:0] m_ptr, m_mbase, m_iobase;

    always #2 clk = ~clk;

    pcib_host_ctrl dut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata),
        .cfg_req_valid(cfg_req_valid), .cfg_req_write(cfg_req_write),
        .cfg_req_addr(cfg_req_addr), .cfg_req_wdata(cfg_req_wdata),
        .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_be(io_be), .io_ready(io_ready),
        .io_rdata(io_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic in_reg(input logic [31:0] a);
        return a[31:10] == RB[31:10] && a[9:0] < 10'h224;
    endfunction

    function automatic logic [31:0] model_read(input logic [31:0] a, input logic [3:0] be);
        logic [9:0] o;
        o = a[9:0];
        if (be != 4'hF || !in_reg(a)) return 32'h0;
        if (o < 10'h100 && o[1:0] == 2'b00) return m_hdr[o[7:2]];
        if (o == 10'h1C0) return m_ptr;
        if (o == 10'h1C4) return m_mbase;
        if (o == 10'h1C8) return m_iobase;
        return 32'h0;
    endfunction

    task automatic model_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [9:0] o;
        o = a[9:0];
        if (be != 4'hF || !in_reg(a)) return;
        if (o < 10'h100 && o[1:0] == 2'b00) m_hdr[o[7:2]] = d;
        else if (o == 10'h1C0) m_ptr = d;
        else if (o == 10'h1C4) m_mbase = d & 32'hFF00_0001;
        else if (o == 10'h1C8) begin
            if (d[31:18] != m_iobase[31:18]) m_iobase = d & 32'hFFFC_0001;
        end
    endtask

    // Single-cycle register-window or out-of-window access.
    task automatic reg_acc(input string req, input logic wr, input logic [31:0] a,
                           input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        #1;
        chk({req, " ready"}, {31'b0, cpu_ready}, 32'h1);
        if (!wr) chk({req, " rdata"}, cpu_rdata, model_read(a, be));
        chk({req, " no io"}, {31'b0, io_valid}, 32'h0);
        @(posedge clk);
        if (wr) model_write(a, d, be);
        #1 cpu_valid = 1'b0;
    endtask

    // Data-port access with a response after lat extra cycles.
    task automatic dport_acc(input string req, input logic wr, input logic [31:0] d,
                             input logic [31:0] rsp, input int lat);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = RB + 32'h220; cpu_wdata = d; cpu_be = 4'hF;
        #1;
        chk({req, " stall0"}, {31'b0, cpu_ready}, 32'h0);
        chk({req, " no req yet"}, {31'b0, cfg_req_valid}, 32'h0);
        @(negedge clk);
        chk({req, " req pulse"}, {31'b0, cfg_req_valid}, 32'h1);
        chk({req, " req write"}, {31'b0, cfg_req_write}, {31'b0, wr});
        chk({req, " req addr"}, cfg_req_addr, m_ptr);
        if (wr) chk({req, " req wdata"}, cfg_req_wdata, d);
        chk({req, " stall1"}, {31'b0, cpu_ready}, 32'h0);
        @(negedge clk);
        for (int i = 0; i < lat; i++) begin
            chk({req, " req dropped"}, {31'b0, cfg_req_valid}, 32'h0);
            chk({req, " stall wait"}, {31'b0, cpu_ready}, 32'h0);
            @(negedge clk);
        end
        cfg_rsp_valid = 1'b1; cfg_rsp_rdata = rsp;
        #1;
        chk({req, " done"}, {31'b0, cpu_ready}, 32'h1);
        if (!wr) chk({req, " rsp data"}, cpu_rdata, rsp);
        @(posedge clk);
        #1 cpu_valid = 1'b0; cfg_rsp_valid = 1'b0;
    endtask

    // I/O window access.
    task automatic io_acc(input string req, input logic wr, input logic [31:0] a,
                          input logic [31:0] d, input logic [3:0] be, input logic hit);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        io_rdata = 32'hC0DE_0000 | {16'h0, a[15:0]};
        io_ready = 1'b0;
        #1;
        chk({req, " io_valid"}, {31'b0, io_valid}, {31'b0, hit});
        if (hit) begin
            chk({req, " io stall"}, {31'b0, cpu_ready}, 32'h0);
            io_ready = 1'b1;
            #1;
            chk({req, " io_addr"}, {14'h0, io_addr}, {14'h0, a[17:0]});
            chk({req, " io_write"}, {31'b0, io_write}, {31'b0, wr});
            chk({req, " io_be"}, {28'h0, io_be}, {28'h0, be});
            if (wr) chk({req, " io_wdata"}, io_wdata, d);
            chk({req, " io ready"}, {31'b0, cpu_ready}, 32'h1);
            if (!wr) chk({req, " io rdata"}, cpu_rdata, io_rdata);
        end else begin
            chk({req, " miss ready"}, {31'b0, cpu_ready}, 32'h1);
            chk({req, " miss rdata"}, cpu_rdata, 32'h0);
        end
        @(posedge clk);
        #1 cpu_valid = 1'b0; io_ready = 1'b1;
    endtask

    // Every-clock comparison: with no access, nothing is forwarded.
    always @(negedge clk) begin
        if (!rst && !cpu_valid) begin
            chk("R7 idle no cfg req", {31'b0, cfg_req_valid}, 32'h0);
            chk("R6 idle no io", {31'b0, io_valid}, 32'h0);
        end
    end

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) m_hdr[i] = 32'h0;
        m_hdr[1] = {STS, CMD};
        m_ptr = 32'h0; m_mbase = 32'h0; m_iobase = 32'hFE24_0000;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // Reset state: R2 R3 R4 R5
        reg_acc("R2 reset cmd/status", 1'b0, RB + 32'h004, 0, 4'hF);
        reg_acc("R2 reset word0", 1'b0, RB + 32'h000, 0, 4'hF);
        reg_acc("R3 reset ptr", 1'b0, RB + 32'h1C0, 0, 4'hF);
        reg_acc("R4 reset mbase", 1'b0, RB + 32'h1C4, 0, 4'hF);
        reg_acc("R5 reset iobase", 1'b0, RB + 32'h1C8, 0, 4'hF);

        // Header read/write: R2 R10
        reg_acc("R10 hdr write", 1'b1, RB + 32'h03C, 32'h1234_5678, 4'hF);
        reg_acc("R2 hdr readback", 1'b0, RB + 32'h03C, 0, 4'hF);
        reg_acc("R2 hdr last write", 1'b1, RB + 32'h0FC, 32'hA5A5_5A5A, 4'hF);
        reg_acc("R2 hdr last read", 1'b0, RB + 32'h0FC, 0, 4'hF);
        reg_acc("R2 hdr cmd overwrite", 1'b1, RB + 32'h004, 32'hFFFF_0007, 4'hF);
        reg_acc("R2 hdr cmd read", 1'b0, RB + 32'h004, 0, 4'hF);

        // Pointer and memory base masks: R3 R4
        reg_acc("R3 ptr write", 1'b1, RB + 32'h1C0, 32'h8000_0A5C, 4'hF);
        reg_acc("R3 ptr read", 1'b0, RB + 32'h1C0, 0, 4'hF);
        reg_acc("R4 mbase write", 1'b1, RB + 32'h1C4, 32'hFFFF_FFFF, 4'hF);
        reg_acc("R4 mbase read", 1'b0, RB + 32'h1C4, 0, 4'hF);
        chk("R4 mbase mask value", m_mbase, 32'hFF00_0001);

        // Partial accesses: R1
        reg_acc("R1 partial ptr write", 1'b1, RB + 32'h1C0, 32'h0BAD_0BAD, 4'h3);
        reg_acc("R1 ptr unchanged", 1'b0, RB + 32'h1C0, 0, 4'hF);
        reg_acc("R1 partial read zero", 1'b0, RB + 32'h1C0, 0, 4'h1);
        reg_acc("R1 partial hdr write", 1'b1, RB + 32'h03C, 32'hDEAD_BEEF, 4'hE);
        reg_acc("R1 hdr unchanged", 1'b0, RB + 32'h03C, 0, 4'hF);

        // Unmapped and outside addresses: R9
        reg_acc("R9 gap write", 1'b1, RB + 32'h100, 32'hFFFF_FFFF, 4'hF);
        reg_acc("R9 gap read", 1'b0, RB + 32'h100, 0, 4'hF);
        reg_acc("R9 1CC read", 1'b0, RB + 32'h1CC, 0, 4'hF);
        reg_acc("R9 21C write", 1'b1, RB + 32'h21C, 32'h1111_1111, 4'hF);
        reg_acc("R9 21C read", 1'b0, RB + 32'h21C, 0, 4'hF);
        reg_acc("R9 outside read", 1'b0, 32'h0000_1000, 0, 4'hF);
        reg_acc("R9 past window read", 1'b0, RB + 32'h224, 0, 4'hF);
        reg_acc("R9 ptr kept", 1'b0, RB + 32'h1C0, 0, 4'hF);

        // I/O window at reset base: R6
        io_acc("R6 hit read", 1'b0, 32'hFE24_1234, 0, 4'hF, 1'b1);
        io_acc("R6 hit write top", 1'b1, 32'hFE27_FFFC, 32'h5555_AAAA, 4'h5, 1'b1);
        io_acc("R6 miss above", 1'b0, 32'hFE28_0000, 0, 4'hF, 1'b0);
        io_acc("R6 miss below", 1'b0, 32'hFE23_FFFC, 0, 4'hF, 1'b0);

        // Conditional I/O base update: R5
        reg_acc("R5 iobase move", 1'b1, RB + 32'h1C8, 32'hA000_0003, 4'hF);
        reg_acc("R5 iobase masked", 1'b0, RB + 32'h1C8, 0, 4'hF);
        chk("R5 iobase mask value", m_iobase, 32'hA000_0001);
        reg_acc("R5 same hi write", 1'b1, RB + 32'h1C8, 32'hA000_1000, 4'hF);
        reg_acc("R5 same hi kept", 1'b0, RB + 32'h1C8, 0, 4'hF);
        chk("R5 same hi value", m_iobase, 32'hA000_0001);
        reg_acc("R5 new hi write", 1'b1, RB + 32'h1C8, 32'hA004_0000, 4'hF);
        reg_acc("R5 new hi read", 1'b0, RB + 32'h1C8, 0, 4'hF);
        io_acc("R6 hit after move", 1'b0, 32'hA004_0010, 0, 4'hF, 1'b1);
        io_acc("R6 old base miss", 1'b0, 32'hFE24_1234, 0, 4'hF, 1'b0);

        // Data port: R7 R8
        reg_acc("R7 set ptr", 1'b1, RB + 32'h1C0, 32'h8000_0810, 4'hF);
        dport_acc("R7 write lat0", 1'b1, 32'hCAFE_F00D, 32'h0, 0);
        dport_acc("R7 write lat4", 1'b1, 32'h0123_4567, 32'h0, 4);
        reg_acc("R8 set ptr", 1'b1, RB + 32'h1C0, 32'hFFFF_FFFC, 4'hF);
        dport_acc("R8 read lat0", 1'b0, 32'h0, 32'h89AB_CDEF, 0);
        dport_acc("R8 read lat3", 1'b0, 32'h0, 32'h1357_9BDF, 3);
        reg_acc("R8 ptr after dport", 1'b0, RB + 32'h1C0, 0, 4'hF);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule